// File: doc/BRIEF.md
# Serial Motor-Driver Control Register File

This block is the configuration front end of a multi-channel H-bridge motor driver. A host drives three pins: a chip-select, a serial clock and a serial data line. While chip-select is high, each rising serial-clock edge shifts one data bit in, most significant bit first. A transaction that ends with exactly eight bits is a control word. Its upper three bits pick one of eight five-bit registers, and its lower five bits replace that register's contents.

The stored registers go straight to decoded control outputs. These cover the enables for the first channel pair, the channel-3 drive state, a channel-4 serial bit, the four-bit level codes with their constant-voltage/full-swing selects, the channel-5 current-sense code, the parallel-input pair select, the power-save bit and three indicator output enables. Registers 0 and 1 appear as raw five-bit configuration words. There are two ways to clear everything: a write to register 7 with bit 0 set, and the active-low hardware reset pin.

The three serial pins are sampled in the system clock domain through two-flop synchronizers. The system clock must therefore run several times faster than the serial clock.

Top module: `mdrv_serial_cfg`

## Requirements
- R1: A control word is 8 bits, sent MSB first, one bit per rising edge of `sck_i` while `cs_i` is high. Bits 7:5 are the register address and bits 4:0 are the payload written to that register.
- R2: The word is committed when `cs_i` falls. The new register value shows on the outputs after the third rising `clk` edge following the `cs_i` fall, and not after the second.
- R3: A transaction with fewer or more than 8 serial-clock edges is discarded and leaves every register unchanged.
- R4: Register 2 decodes as follows. Bits 4:3 are the channel 1/2 enables (`ch12_en_o`). Bits 2:1 are the channel-3 drive state (`ch3_state_o`: 00 off, 01 forward, 10 reverse, 11 brake). Bit 0 is `ch4_ser_o`.
- R5: Registers 3, 4 and 5 hold a level code in bits 4:1 and a mode select in bit 0 (0 constant-voltage, 1 full-swing). Register 3 drives the channel 1/2 outputs, register 4 the channel-3 outputs and register 5 the channel-4 outputs.
- R6: Register 6 decodes as follows. Bits 4:1 are the channel-5 current-sense code (`lvl5_o`). Bit 0 is the parallel-input pair select (`par_sel_o`: 0 first pair, 1 second pair).
- R7: Register 7 decodes as follows. Bit 4 is `pwr_on_o` (0 standby, 1 active). Bits 3, 2 and 1 drive `ind_en_o[0]`, `ind_en_o[1]` and `ind_en_o[2]`, where 1 means the indicator output is on.
- R8: A committed write to register 7 with bit 0 set clears all eight registers to zero, and the other payload bits of that write are ignored. Bit 0 of register 7 is never retained, so the clear acts once.
- R9: `rst_n` low clears all registers at once, without waiting for a clock edge. Every output reads zero while it is held low.
- R10: `cfg0_o` and `cfg1_o` show the stored payloads of registers 0 and 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| cs_i | input | 1 | Serial chip-select, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data, MSB first |
| cfg0_o | output | 5 | Register 0 payload |
| cfg1_o | output | 5 | Register 1 payload |
| ch12_en_o | output | 2 | Channel 1/2 enables |
| ch3_state_o | output | 2 | Channel-3 drive state |
| ch4_ser_o | output | 1 | Channel-4 serial control bit |
| lvl12_o | output | 4 | Channel 1/2 level code |
| fs12_o | output | 1 | Channel 1/2 full-swing select |
| lvl3_o | output | 4 | Channel-3 level code |
| fs3_o | output | 1 | Channel-3 full-swing select |
| lvl4_o | output | 4 | Channel-4 level code |
| fs4_o | output | 1 | Channel-4 full-swing select |
| lvl5_o | output | 4 | Channel-5 current-sense code |
| par_sel_o | output | 1 | Parallel-input pair select |
| pwr_on_o | output | 1 | Power state, 1 active |
| ind_en_o | output | 3 | Indicator output enables |

## Verification
A serial pin change reaches the decode logic after two synchronizer flops, and the register write takes one more edge. A committed word is therefore due on the outputs after the third rising clock edge that follows the chip-select fall. A hardware reset acts immediately, with no edge needed. The bench drives pins only just after falling clock edges. Its reference model steps the same pin-to-register delay on every rising edge, and the outputs are compared with the model at every falling edge. For the commit latency, a directed check samples the second and the third falling edge after chip-select drops and expects the old and then the new value. The reset check samples a fraction of a cycle after `rst_n` falls, before any clock edge.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 5;
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int NREG     = 1 << ADDR_W;
  localparam int CLR_ADDR = NREG - 1;
  localparam int CLR_BIT  = 0;
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << CLR_BIT;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'b00,
    DRV_FWD   = 2'b01,
    DRV_REV   = 2'b10,
    DRV_BRAKE = 2'b11
  } drv_state_e;
endpackage

// File: rtl/mdrv_rst_sync.sv
module mdrv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdrv_sync.sv
module mdrv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdrv_shift_rx.sv
module mdrv_shift_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              sck_q, cs_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sck_rise, cs_fall, sh_en, cnt_en;

  always_comb begin
    sck_rise = sck_s & ~sck_q;
    cs_fall  = cs_q & ~cs_s;
    sh_en    = cs_s & sck_rise;
    sh_d     = {sh_q[WORD_W-2:0], sdi_s};
    cnt_en   = ~cs_s | (sh_en & (cnt_q != CNT_W'(CNT_MAX)));
    if (!cs_s) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign word_vld = cs_fall & (cnt_q == CNT_W'(WORD_W));
  assign word_o   = sh_q;
endmodule

// File: rtl/mdrv_regfile.sv
module mdrv_regfile
  import mdrv_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NREG*DATA_W-1:0]   regs_flat
);
  logic soft_clr;

  always_comb begin
    soft_clr = wr_en & (wr_addr == ADDR_W'(CLR_ADDR)) & wr_data[CLR_BIT];
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q, d;
    logic              en;
    always_comb begin
      en = soft_clr | (wr_en & (wr_addr == ADDR_W'(i)));
      if (soft_clr)           d = '0;
      else if (i == CLR_ADDR) d = wr_data & ~CLR_MASK;
      else                    d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/mdrv_serial_cfg.sv
module mdrv_serial_cfg
  import mdrv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic [4:0] cfg0_o,
  output logic [4:0] cfg1_o,
  output logic [1:0] ch12_en_o,
  output logic [1:0] ch3_state_o,
  output logic       ch4_ser_o,
  output logic [3:0] lvl12_o,
  output logic       fs12_o,
  output logic [3:0] lvl3_o,
  output logic       fs3_o,
  output logic [3:0] lvl4_o,
  output logic       fs4_o,
  output logic [3:0] lvl5_o,
  output logic       par_sel_o,
  output logic       pwr_on_o,
  output logic [2:0] ind_en_o
);
  logic                   rst_n_q;
  logic                   cs_s, sck_s, sdi_s;
  logic                   word_vld;
  logic [WORD_W-1:0]      rx_word;
  logic [NREG*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0]      rv [NREG];
  drv_state_e             ch3_state;
  logic                   unused_clr_bit;

  mdrv_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_q)
  );

  mdrv_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_q),
    .d_i   ({cs_i, sck_i, sdi_i}),
    .q_o   ({cs_s, sck_s, sdi_s})
  );

  mdrv_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .word_vld (word_vld),
    .word_o   (rx_word)
  );

  mdrv_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .wr_en     (word_vld),
    .wr_addr   (rx_word[WORD_W-1 -: ADDR_W]),
    .wr_data   (rx_word[DATA_W-1:0]),
    .regs_flat (regs_flat)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_view
    assign rv[i] = regs_flat[i*DATA_W +: DATA_W];
  end

  assign ch3_state      = drv_state_e'(rv[2][2:1]);
  assign unused_clr_bit = rv[CLR_ADDR][CLR_BIT];

  assign cfg0_o      = rv[0];
  assign cfg1_o      = rv[1];
  assign ch12_en_o   = rv[2][4:3];
  assign ch3_state_o = ch3_state;
  assign ch4_ser_o   = rv[2][0];
  assign lvl12_o     = rv[3][4:1];
  assign fs12_o      = rv[3][0];
  assign lvl3_o      = rv[4][4:1];
  assign fs3_o       = rv[4][0];
  assign lvl4_o      = rv[5][4:1];
  assign fs4_o       = rv[5][0];
  assign lvl5_o      = rv[6][4:1];
  assign par_sel_o   = rv[6][0];
  assign pwr_on_o    = rv[7][4];
  assign ind_en_o    = {rv[7][1], rv[7][2], rv[7][3]};
endmodule

// File: rtl/mdrv_serial_cfg_chk.sv
module mdrv_serial_cfg_chk
  import mdrv_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_s,
  input logic                   word_vld,
  input logic [WORD_W-1:0]      rx_word,
  input logic [NREG*DATA_W-1:0] regs_flat
);
  logic [ADDR_W-1:0] w_addr;
  logic              is_clr;
  logic              pend_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_data_q;
  logic [DATA_W-1:0] p_slice;

  assign w_addr = rx_word[WORD_W-1 -: ADDR_W];
  assign is_clr = word_vld && (w_addr == ADDR_W'(CLR_ADDR)) && rx_word[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      p_addr_q <= '0;
      p_data_q <= '0;
    end else begin
      pend_q   <= word_vld && !is_clr;
      p_addr_q <= w_addr;
      p_data_q <= (w_addr == ADDR_W'(CLR_ADDR)) ? (rx_word[DATA_W-1:0] & ~CLR_MASK)
                                                 : rx_word[DATA_W-1:0];
    end
  end

  always_comb p_slice = regs_flat[int'(p_addr_q)*DATA_W +: DATA_W];

  assert_word_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (p_slice == p_data_q));

  assert_commit_on_cs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (!cs_s && $past(cs_s)));

  assert_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(regs_flat));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> (regs_flat == '0));

  assert_clr_bit_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[CLR_ADDR*DATA_W + CLR_BIT] == 1'b0);
endmodule

bind mdrv_serial_cfg mdrv_serial_cfg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .word_vld  (word_vld),
  .rx_word   (rx_word),
  .regs_flat (regs_flat)
);

// File: tb/sim_mdrv_serial_cfg.sv
`timescale 1ns/1ps
module sim_mdrv_serial_cfg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0;
  logic [4:0] cfg0_o, cfg1_o;
  logic [1:0] ch12_en_o, ch3_state_o;
  logic       ch4_ser_o, fs12_o, fs3_o, fs4_o, par_sel_o, pwr_on_o;
  logic [3:0] lvl12_o, lvl3_o, lvl4_o, lvl5_o;
  logic [2:0] ind_en_o;

  always #2 clk = ~clk;

  mdrv_serial_cfg u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .ch12_en_o(ch12_en_o),
    .ch3_state_o(ch3_state_o), .ch4_ser_o(ch4_ser_o),
    .lvl12_o(lvl12_o), .fs12_o(fs12_o), .lvl3_o(lvl3_o), .fs3_o(fs3_o),
    .lvl4_o(lvl4_o), .fs4_o(fs4_o), .lvl5_o(lvl5_o), .par_sel_o(par_sel_o),
    .pwr_on_o(pwr_on_o), .ind_en_o(ind_en_o)
  );

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: pin history, bit counter, eight stored payloads
  logic [4:0] m_reg [8];
  logic [7:0] m_sh = '0;
  int         m_cnt = 0;
  logic [2:0] m_p1 = '0, m_p2 = '0, m_pd = '0; // {cs, sck, sdi}

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_sh = '0; m_cnt = 0; m_p1 = '0; m_p2 = '0; m_pd = '0;
    end else begin
      if (m_pd[2] && !m_p2[2] && m_cnt == 8) begin
        if (m_sh[7:5] == 3'd7 && m_sh[0]) begin
          for (int i = 0; i < 8; i++) m_reg[i] = '0;
        end else if (m_sh[7:5] == 3'd7) m_reg[7] = {m_sh[4:1], 1'b0};
        else m_reg[m_sh[7:5]] = m_sh[4:0];
      end
      if (!m_p2[2]) m_cnt = 0;
      else if (m_p2[1] && !m_pd[1]) begin
        m_sh = {m_sh[6:0], m_p2[0]};
        if (m_cnt < 9) m_cnt++;
      end
      m_pd = m_p2; m_p2 = m_p1; m_p1 = {cs_i, sck_i, sdi_i};
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      chk({cfg0_o, cfg1_o} == {m_reg[0], m_reg[1]}, "R10 model", {cfg0_o, cfg1_o}, {m_reg[0], m_reg[1]});
      chk({ch12_en_o, ch3_state_o, ch4_ser_o} == m_reg[2], "R4 model",
          {ch12_en_o, ch3_state_o, ch4_ser_o}, m_reg[2]);
      chk({lvl12_o, fs12_o, lvl3_o, fs3_o, lvl4_o, fs4_o} == {m_reg[3], m_reg[4], m_reg[5]}, "R5 model",
          {lvl12_o, fs12_o, lvl3_o, fs3_o, lvl4_o, fs4_o}, {m_reg[3], m_reg[4], m_reg[5]});
      chk({lvl5_o, par_sel_o} == m_reg[6], "R6 model", {lvl5_o, par_sel_o}, m_reg[6]);
      chk({pwr_on_o, ind_en_o[0], ind_en_o[1], ind_en_o[2]} == m_reg[7][4:1], "R7 model",
          {pwr_on_o, ind_en_o[0], ind_en_o[1], ind_en_o[2]}, m_reg[7][4:1]);
    end
  end

  function automatic logic [41:0] all_out();
    return {cfg0_o, cfg1_o, ch12_en_o, ch3_state_o, ch4_ser_o, lvl12_o, fs12_o,
            lvl3_o, fs3_o, lvl4_o, fs4_o, lvl5_o, par_sel_o, pwr_on_o, ind_en_o};
  endfunction

  // Send n bits of v, MSB first; optionally return right after cs drops
  task automatic xfer(input logic [15:0] v, input int n, input bit settle);
    @(negedge clk); cs_i = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_i = v[i];
      repeat (3) @(negedge clk); sck_i = 1'b1;
      repeat (3) @(negedge clk); sck_i = 1'b0;
    end
    repeat (3) @(negedge clk); cs_i = 1'b0; sdi_i = 1'b0;
    if (settle) repeat (8) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 100000 && !done) @(posedge clk) cycles++;
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", cycles, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(all_out() == '0, "R9 reset state", int'(all_out()), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    cmp_on = 1'b1;

    xfer(16'b000_10101, 8, 1);
    chk(cfg0_o == 5'h15, "R1 reg0 write", cfg0_o, 5'h15);
    xfer(16'b001_01010, 8, 1);
    chk(cfg1_o == 5'h0A, "R10 reg1 raw", cfg1_o, 5'h0A);
    chk(cfg0_o == 5'h15, "R1 reg0 kept", cfg0_o, 5'h15);

    xfer(16'b010_11_10_1, 8, 1);
    chk(ch12_en_o == 2'b11, "R4 enables", ch12_en_o, 2'b11);
    chk(ch3_state_o == 2'b10, "R4 reverse state", ch3_state_o, 2'b10);
    chk(ch4_ser_o == 1'b1, "R4 ch4 bit", ch4_ser_o, 1);
    xfer(16'b010_01_11_0, 8, 1);
    chk(ch3_state_o == 2'b11, "R4 brake state", ch3_state_o, 2'b11);

    xfer(16'b011_1001_1, 8, 1);
    xfer(16'b100_0110_0, 8, 1);
    xfer(16'b101_1111_1, 8, 1);
    chk({lvl12_o, fs12_o} == 5'b1001_1, "R5 ch12", {lvl12_o, fs12_o}, 5'b10011);
    chk({lvl3_o, fs3_o} == 5'b0110_0, "R5 ch3", {lvl3_o, fs3_o}, 5'b01100);
    chk({lvl4_o, fs4_o} == 5'b1111_1, "R5 ch4", {lvl4_o, fs4_o}, 5'b11111);

    xfer(16'b110_0011_1, 8, 1);
    chk(lvl5_o == 4'h3 && par_sel_o, "R6 ch5 and pair", {lvl5_o, par_sel_o}, 5'b00111);

    xfer(16'b111_1_0_1_1_0, 8, 1);
    chk(pwr_on_o == 1'b1, "R7 power", pwr_on_o, 1);
    chk(ind_en_o == 3'b110, "R7 indicators", ind_en_o, 3'b110);

    xfer(16'b000_0000, 7, 1);
    chk(cfg0_o == 5'h15, "R3 short frame", cfg0_o, 5'h15);
    xfer(16'b0_000_00000, 9, 1);
    chk(cfg0_o == 5'h15, "R3 long frame", cfg0_o, 5'h15);
    xfer(16'b1_111_11111, 9, 1);
    chk(pwr_on_o == 1'b1, "R3 long frame no clear", pwr_on_o, 1);

    xfer(16'b000_00011, 8, 0);
    @(negedge clk); @(negedge clk);
    chk(cfg0_o == 5'h15, "R2 not yet at edge 2", cfg0_o, 5'h15);
    @(negedge clk);
    chk(cfg0_o == 5'h03, "R2 due at edge 3", cfg0_o, 5'h03);
    repeat (6) @(negedge clk);

    xfer(16'b111_1011_1, 8, 1);
    chk(all_out() == '0, "R8 soft clear", int'(all_out()), 0);
    xfer(16'b011_0001_0, 8, 1);
    repeat (10) @(negedge clk);
    chk(lvl12_o == 4'h1, "R8 clear acts once", lvl12_o, 1);

    xfer(16'b111_10000, 8, 1);
    xfer(16'b001_11111, 8, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk(all_out() == '0, "R9 async reset", int'(all_out()), 0);
    repeat (3) @(negedge clk);
    chk(all_out() == '0, "R9 held reset", int'(all_out()), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    xfer(16'b001_00110, 8, 1);
    chk(cfg1_o == 5'h06, "R1 write after reset", cfg1_o, 5'h06);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule